// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block holds up to six instruction bytes between a word-wide bus fetch engine and a byte-wide instruction decoder. It asks the bus sequencer for the next 16-bit word whenever at least two byte slots are free and the execution side has no data access waiting. It appends each returned word to the tail of the queue and hands single bytes to the decoder from the head.

A taken branch is signalled with a flush strobe and a target offset. The flush discards every queued byte and moves fetching to the target. An odd target is handled by dropping the low byte of the first word fetched after the flush.

A registered 2-bit status code tells an external coprocessor what the queue did in the previous cycle. With this code the coprocessor can follow the instruction stream without decoding it.

Top module: `prefetchQueue`

## Requirements
- R1: Bytes leave the queue in the order they entered. `byteOut` shows the head byte whenever `byteValid` is high, and `byteValid` is high exactly when at least one byte is held.
- R2: `fetchReq` is high exactly when at most DEPTH-2 bytes are held, `dataBusy` is low and `flushReq` is low. The queue never holds more than DEPTH bytes.
- R3: A completed fetch is a cycle with `fetchReq` and `fetchAck` both high. It appends `fetchData[7:0]` and then `fetchData[15:8]`, which correspond to the even and the following odd address.
- R4: While `dataBusy` is high, no fetch is requested and an asserted `fetchAck` adds nothing.
- R5: In the cycle after `flushReq`, the queue is empty. The next fetch then goes to the word that contains `flushTarget`.
- R6: `fetchAddr` is always even. After each completed fetch it advances by 2.
- R7: When `flushTarget` is odd, the first completed fetch after the flush queues only `fetchData[15:8]`. Fetches after that queue both bytes.
- R8: A `popReq` while the queue is empty changes nothing: the status code stays 00 and no byte is lost.
- R9: A `fetchAck` in the same cycle as `flushReq` is dropped, and the queue stays empty.
- R10: `qStatus` reports the previous cycle's action with these codes. 10 means a flush. 01 means a byte was taken with `popFirst` high. 11 means a byte was taken with `popFirst` low. 00 means none of these happened. A flush outranks a pop in the same cycle.
- R11: After reset the queue is empty, `qStatus` is 00 and `fetchAddr` equals RESET_ADDR, which is 0 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| fetchReq | output | 1 | Word fetch request to the bus sequencer |
| fetchAddr | output | ADDR_W | Even offset of the word requested |
| fetchAck | input | 1 | Fetch completes this cycle when high with fetchReq |
| fetchData | input | 16 | Word returned by the bus sequencer |
| dataBusy | input | 1 | Execution side has a data access pending |
| byteValid | output | 1 | Head byte is available |
| byteOut | output | 8 | Head byte |
| popReq | input | 1 | Decoder takes the head byte |
| popFirst | input | 1 | Byte taken is the first byte of an opcode |
| flushReq | input | 1 | Taken branch: discard queue |
| flushTarget | input | ADDR_W | Branch target offset |
| qStatus | output | 2 | Registered queue status code |

## Verification
Three actions can fall in the same cycle: a flush, a word completion and a pop. The bench drives a flush together with a pop and with an asserted acknowledge, in directed cases and again in a long pseudo-random phase. It judges the result in three ways. The status code in the next cycle must be 10. The queue must come back empty. The next bytes the decoder receives must come from the target address. A pop in the same cycle as a completion is also provoked often, and the head order is checked against a scoreboard of expected addresses.

// File: rtl/pfqPkg.sv
`timescale 1ns/1ps
package pfqPkg;
  // strobes from control to datapath, one cycle worth
  typedef struct packed {
    logic flush;    // drop all bytes, reset pointers
    logic pushTwo;  // append low then high byte of fetch word
    logic pushHi;   // append only high byte (odd target)
    logic pop;      // remove head byte
  } pfqStrobeT;

  typedef enum logic [1:0] {
    QS_IDLE  = 2'b00,
    QS_FIRST = 2'b01,
    QS_FLUSH = 2'b10,
    QS_NEXT  = 2'b11
  } qStatT;
endpackage

// File: rtl/pfqData.sv
`timescale 1ns/1ps
module pfqData
  import pfqPkg::*;
#(
  parameter int DEPTH = 6
) (
  input  logic      clk,
  input  logic      rstN,
  input  pfqStrobeT strb,
  input  logic [15:0] fetchData,
  output logic [7:0]  byteOut
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PTR_W-1:0] rdPtr, wrPtr, wrPtrNext1;
  logic [7:0] slot [DEPTH];

  function automatic logic [PTR_W-1:0] ptrAdd(input logic [PTR_W-1:0] p, input int unsigned n);
    int unsigned s;
    s = int'(p) + n;
    if (s >= DEPTH) s = s - DEPTH;
    return PTR_W'(s);
  endfunction

  assign wrPtrNext1 = ptrAdd(wrPtr, 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
    end else if (strb.flush) begin
      rdPtr <= '0;
      wrPtr <= '0;
    end else begin
      if (strb.pop) rdPtr <= ptrAdd(rdPtr, 1);
      if (strb.pushTwo) wrPtr <= ptrAdd(wrPtr, 2);
      else if (strb.pushHi) wrPtr <= wrPtrNext1;
    end
  end

  // per-slot write decode
  for (genvar i = 0; i < DEPTH; i++) begin : gSlot
    logic wrLo, wrHi;
    assign wrLo = strb.pushTwo && (wrPtr == PTR_W'(i));
    assign wrHi = (strb.pushTwo && (wrPtrNext1 == PTR_W'(i))) ||
                  (strb.pushHi  && (wrPtr == PTR_W'(i)));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)     slot[i] <= '0;
      else if (wrLo) slot[i] <= fetchData[7:0];
      else if (wrHi) slot[i] <= fetchData[15:8];
    end
  end

  assign byteOut = slot[rdPtr];

  // R9
  no_write_on_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.flush |-> !(strb.pushTwo || strb.pushHi));
  // R7
  push_kind_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.pushTwo, strb.pushHi}));
  // R5
  flush_ptr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.flush |=> (rdPtr == wrPtr));
endmodule

// File: rtl/pfqCtrl.sv
`timescale 1ns/1ps
module pfqCtrl
  import pfqPkg::*;
#(
  parameter int DEPTH = 6,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dataBusy,
  input  logic              fetchAck,
  input  logic              popReq,
  input  logic              popFirst,
  input  logic              flushReq,
  input  logic [ADDR_W-1:0] flushTarget,
  output logic              fetchReq,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic              byteValid,
  output logic [1:0]        qStatus,
  output pfqStrobeT         strb
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] ROOM_LIMIT = CNT_W'(DEPTH - 2);

  logic [CNT_W-1:0]  cnt, cntNext;
  logic [ADDR_W-1:0] pc;
  logic              skipLo;
  qStatT             statQ, statNext;
  logic              done;

  assign fetchAddr = {pc[ADDR_W-1:1], 1'b0};
  assign byteValid = (cnt != '0);
  assign fetchReq  = (cnt <= ROOM_LIMIT) && !dataBusy && !flushReq;
  assign done      = fetchReq && fetchAck;

  always_comb begin
    strb.flush   = flushReq;
    strb.pop     = popReq && byteValid && !flushReq;
    strb.pushTwo = done && !skipLo;
    strb.pushHi  = done && skipLo;
  end

  always_comb begin
    cntNext = cnt;
    if (strb.flush) cntNext = '0;
    else begin
      if (strb.pop)          cntNext = cntNext - CNT_W'(1);
      if (strb.pushTwo)      cntNext = cntNext + CNT_W'(2);
      else if (strb.pushHi)  cntNext = cntNext + CNT_W'(1);
    end
  end

  always_comb begin
    if (flushReq)      statNext = QS_FLUSH;
    else if (strb.pop) statNext = popFirst ? QS_FIRST : QS_NEXT;
    else               statNext = QS_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      pc     <= RESET_ADDR;
      skipLo <= RESET_ADDR[0];
      statQ  <= QS_IDLE;
    end else begin
      cnt   <= cntNext;
      statQ <= statNext;
      if (flushReq) begin
        pc     <= flushTarget;
        skipLo <= flushTarget[0];
      end else if (done) begin
        pc     <= fetchAddr + ADDR_W'(2);
        skipLo <= 1'b0;
      end
    end
  end

  assign qStatus = statQ;

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_W'(DEPTH));
  // R4
  pause_on_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataBusy |-> !fetchReq);
  // R5
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |=> !byteValid);
  // R10
  flush_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |=> (qStatus == 2'b10));
  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReq && fetchAck) |=> (fetchAddr == $past(fetchAddr) + ADDR_W'(2)));
  // R8
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && !byteValid && !flushReq) |=> (qStatus == 2'b00));
endmodule

// File: rtl/prefetchQueue.sv
`timescale 1ns/1ps
module prefetchQueue
  import pfqPkg::*;
#(
  parameter int DEPTH = 6,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rstN,
  output logic              fetchReq,
  output logic [ADDR_W-1:0] fetchAddr,
  input  logic              fetchAck,
  input  logic [15:0]       fetchData,
  input  logic              dataBusy,
  output logic              byteValid,
  output logic [7:0]        byteOut,
  input  logic              popReq,
  input  logic              popFirst,
  input  logic              flushReq,
  input  logic [ADDR_W-1:0] flushTarget,
  output logic [1:0]        qStatus
);
  pfqStrobeT strb;

  pfqCtrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .RESET_ADDR(RESET_ADDR)) uCtrl (
    .clk(clk), .rstN(rstN), .dataBusy(dataBusy), .fetchAck(fetchAck),
    .popReq(popReq), .popFirst(popFirst), .flushReq(flushReq),
    .flushTarget(flushTarget), .fetchReq(fetchReq), .fetchAddr(fetchAddr),
    .byteValid(byteValid), .qStatus(qStatus), .strb(strb)
  );

  pfqData #(.DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .fetchData(fetchData), .byteOut(byteOut)
  );
endmodule

// File: tb/test_prefetchQueue.sv
`timescale 1ns/1ps
module test_prefetchQueue;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fetchReq, fetchAck, dataBusy, byteValid, popReq, popFirst, flushReq;
  logic [15:0] fetchAddr, fetchData, flushTarget;
  logic [7:0] byteOut;
  logic [1:0] qStatus;

  always #5 clk = ~clk;

  prefetchQueue i_prefetchQueue (
    .clk(clk), .rstN(rstN), .fetchReq(fetchReq), .fetchAddr(fetchAddr),
    .fetchAck(fetchAck), .fetchData(fetchData), .dataBusy(dataBusy),
    .byteValid(byteValid), .byteOut(byteOut), .popReq(popReq),
    .popFirst(popFirst), .flushReq(flushReq), .flushTarget(flushTarget),
    .qStatus(qStatus)
  );

  int nCmp = 0;
  int nBad = 0;
  logic [15:0] sb[$];      // scoreboard: addresses of queued bytes
  logic [15:0] modelPc = 16'h0000;
  bit modelSkip = 1'b0;
  logic [1:0] expStat = 2'b00;

  function automatic logic [7:0] memByte(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic finish();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  // one cycle: driver sets inputs, monitor compares against scoreboard
  task automatic step(input bit dBusy, input bit flush, input logic [15:0] tgt,
                      input bit pop, input bit first, input bit ack);
    bit expReq;
    logic [15:0] wa;
    @(negedge clk);
    chk(qStatus == expStat, "R10", "qStatus", qStatus, expStat);
    dataBusy = dBusy; flushReq = flush; flushTarget = tgt;
    popReq = pop; popFirst = first; fetchAck = ack;
    wa = {modelPc[15:1], 1'b0};
    fetchData = {memByte(wa + 16'd1), memByte(wa)};
    #1;
    chk(byteValid == (sb.size() != 0), "R1", "byteValid", byteValid, sb.size() != 0);
    expReq = !dBusy && !flush && (sb.size() <= 4);
    chk(fetchReq == expReq, dBusy ? "R4" : "R2", "fetchReq", fetchReq, expReq);
    if (expReq) chk(fetchAddr == wa, "R6", "fetchAddr", fetchAddr, wa);
    if (flush) begin
      sb.delete();
      modelPc = tgt;
      modelSkip = tgt[0];
      expStat = 2'b10;
    end else begin
      if (pop && sb.size() > 0) begin
        logic [15:0] ea;
        ea = sb.pop_front();
        chk(byteOut == memByte(ea), "R1", "byteOut", byteOut, memByte(ea));
        expStat = first ? 2'b01 : 2'b11;
      end else begin
        expStat = 2'b00;
      end
      if (expReq && ack) begin
        if (modelSkip) sb.push_back(wa + 16'd1);   // R7
        else begin sb.push_back(wa); sb.push_back(wa + 16'd1); end  // R3
        modelSkip = 1'b0;
        modelPc = wa + 16'd2;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nCmp++; nBad++;
    $display("FAIL watchdog: actual running expected done");
    finish();
  end

  initial begin
    dataBusy = 0; flushReq = 0; flushTarget = 0; popReq = 0; popFirst = 0;
    fetchAck = 0; fetchData = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R11 reset state
    chk(byteValid == 1'b0, "R11", "byteValid", byteValid, 0);
    chk(qStatus == 2'b00, "R11", "qStatus", qStatus, 0);
    chk(fetchAddr == 16'h0000, "R11", "fetchAddr", fetchAddr, 0);

    // fill to full: R2, R3
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 0, 1);
    chk(sb.size() == 6, "R2", "model fill", sb.size(), 6);
    // drain with first/next codes: R1, R10
    for (int i = 0; i < 7; i++) step(0, 0, 0, 1, (i % 3) == 0, 0);
    // pop empty: R8
    step(0, 0, 0, 1, 1, 0);
    step(0, 0, 0, 0, 0, 0);
    // data access pending, ack ignored: R4
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 1);
    // flush with pop and ack same cycle: R5, R9, R10
    step(0, 1, 16'h1234, 1, 1, 1);
    step(0, 0, 0, 1, 1, 0);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 1, 1);
    // odd target: R7
    step(0, 1, 16'h2001, 0, 0, 0);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 6; i++) step(0, 0, 0, 1, i == 0, 0);
    // odd target at top of space with wrap
    step(0, 1, 16'hFFFF, 0, 0, 0);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 0, 1);
    // pseudo-random mix
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      step(r < 20, $urandom_range(0, 99) < 4, 16'($urandom()),
           $urandom_range(0, 1) == 1, $urandom_range(0, 2) == 0,
           $urandom_range(0, 99) < 60);
    end
    step(0, 0, 0, 0, 0, 0);
    @(negedge clk);
    chk(qStatus == expStat, "R10", "final qStatus", qStatus, expStat);
    finish();
  end
endmodule